// File: doc/BRIEF.md
# Crate Controller Status and Control Register

This block is the 16-bit status and control register of a crate controller. A host issues commands made of a function code and a subaddress, plus 16 bits of write data, on a single-cycle command port. The register can be read whole, written whole, have bits set or cleared under a data mask, and deliver the crate's attention-request pattern. The last value read can be fetched again.

Each bit has its own access rule. Some bits hold control values that drive outputs. Some only reflect status inputs. Two bits store nothing and instead fire a one-clock strobe toward the backplane. One control bit is written as a request but reads back the actual external state. Every accepted command raises a response flag for one cycle. Command codes the block does not support get no response and change nothing.

In this brief, bit n (1..16) is data bit n-1. Commands are given as function/subaddress pairs in decimal.

Top module: `crate_stat_reg`

## Requirements
- R1: During and after reset the control outputs are ctl_inhibit=1, bypass=1, offline_ctl=1, and demand_en=0, int_demand=0, loop_collapse=0. Strobes, rsp_ok and rd_data are 0, and the re-read value is 0.
- R2: Command 1/0 returns the status word on rd_data. Data bit 2 is ctl_inhibit. Bits 3, 4, 5 and 6 are err_flag, noresp_flag, resp_flag and inhibit_state. Bits 8 to 11 are demand_en, int_demand, loop_collapse and bypass. Bit 12 is offline_actual, bit 13 is switch_offline and bit 15 is attn_present. Bits 0, 1, 7 and 14 read 0.
- R3: Command 1/12 returns attn_pattern on rd_data.
- R4: Command 0/1 returns the value of the most recent 1/0 or 1/12 read, even when other commands came in between.
- R5: Command 17/0 loads the writable data bits 2, 8, 9, 10, 11 and 12 from cmd_wdata.
- R6: Command 19/0 sets each writable bit whose cmd_wdata bit is 1 and leaves the others unchanged.
- R7: Command 23/0 clears each writable bit whose cmd_wdata bit is 1 and leaves the others unchanged.
- R8: A 17/0 or 19/0 command with cmd_wdata bit 0 (or bit 1) set pulses init_strobe (or clear_strobe) for exactly one cycle. Those two bits always read 0, and 23/0 fires no strobe.
- R9: Writable data bit 12 drives offline_ctl. A status read of that bit returns offline_actual, not the stored value.
- R10: Writes to read-only and reserved bits (3 to 7, 13 to 15) have no effect on any output or on the status word.
- R11: Every supported command sets rsp_ok for the one cycle after it. rd_data is 0 after any non-read command.
- R12: An unsupported function/subaddress pair leaves rsp_ok and rd_data at 0, fires no strobe, and leaves the control outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_func | input | 5 | Function code |
| cmd_sub | input | 4 | Subaddress |
| cmd_wdata | input | 16 | Write data or mask |
| err_flag | input | 1 | Error status (data bit 3) |
| noresp_flag | input | 1 | No-response status (data bit 4) |
| resp_flag | input | 1 | Response status (data bit 5) |
| inhibit_state | input | 1 | Actual backplane inhibit (data bit 6) |
| offline_actual | input | 1 | Actual off-line state (data bit 12) |
| switch_offline | input | 1 | Off-line switch (data bit 13) |
| attn_present | input | 1 | Selected attention requests present (data bit 15) |
| attn_pattern | input | 16 | Attention-request pattern |
| rd_data | output | 16 | Read result |
| rsp_ok | output | 1 | Command accepted |
| init_strobe | output | 1 | One-cycle initialize strobe |
| clear_strobe | output | 1 | One-cycle clear strobe |
| ctl_inhibit | output | 1 | Inhibit control bit |
| demand_en | output | 1 | Demand enable |
| int_demand | output | 1 | Internal demand |
| loop_collapse | output | 1 | Loop collapse control |
| bypass | output | 1 | Bypass control |
| offline_ctl | output | 1 | Requested off-line control |

## Verification
Every result of a command sampled at clock edge k is due exactly one cycle later: rd_data, rsp_ok, the strobes and the updated control outputs all come from registers loaded at edge k. Status inputs are sampled at the same edge as the command. The bench drives each command on a falling edge and checks every output on the next falling edge. It then idles one cycle and checks that the strobes, rsp_ok and rd_data have gone back to 0. This catches strobes that last longer than one cycle and read data that does not clear.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int REG_W = 16;

  // data-bit positions whose meaning is fixed by behaviour
  localparam int B_INIT    = 0;
  localparam int B_CLEAR   = 1;
  localparam int B_INH     = 2;
  localparam int B_ERR     = 3;
  localparam int B_NORSP   = 4;
  localparam int B_RSP     = 5;
  localparam int B_INHACT  = 6;
  localparam int B_DEMEN   = 8;
  localparam int B_INTDEM  = 9;
  localparam int B_LOOP    = 10;
  localparam int B_BYP     = 11;
  localparam int B_OFFL    = 12;
  localparam int B_SWOFF   = 13;
  localparam int B_ATTN    = 15;
  localparam int N_STROBE  = 2;

  localparam logic [REG_W-1:0] WR_MASK =
    REG_W'((1 << B_INH) | (1 << B_DEMEN) | (1 << B_INTDEM) |
           (1 << B_LOOP) | (1 << B_BYP) | (1 << B_OFFL));
  localparam logic [REG_W-1:0] RST_VAL =
    REG_W'((1 << B_INH) | (1 << B_BYP) | (1 << B_OFFL));

  localparam int F_REREAD = 0;
  localparam int F_READ   = 1;
  localparam int F_WRITE  = 17;
  localparam int F_SET    = 19;
  localparam int F_CLR    = 23;
  localparam int S_MAIN   = 0;
  localparam int S_AGAIN  = 1;
  localparam int S_ATTN   = 12;

  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_ATTN, OP_REREAD, OP_WRITE, OP_SET, OP_CLR
  } csr_op_e;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
#(
  parameter int FUNC_W = 5,
  parameter int SUB_W  = 4
) (
  input  logic              cmd_valid,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic [SUB_W-1:0]  cmd_sub,
  output csr_op_e           op
);
  always_comb begin
    op = OP_NONE;
    if (cmd_valid) begin
      if (cmd_func == FUNC_W'(F_READ) && cmd_sub == SUB_W'(S_MAIN))
        op = OP_READ;
      else if (cmd_func == FUNC_W'(F_READ) && cmd_sub == SUB_W'(S_ATTN))
        op = OP_ATTN;
      else if (cmd_func == FUNC_W'(F_REREAD) && cmd_sub == SUB_W'(S_AGAIN))
        op = OP_REREAD;
      else if (cmd_func == FUNC_W'(F_WRITE) && cmd_sub == SUB_W'(S_MAIN))
        op = OP_WRITE;
      else if (cmd_func == FUNC_W'(F_SET) && cmd_sub == SUB_W'(S_MAIN))
        op = OP_SET;
      else if (cmd_func == FUNC_W'(F_CLR) && cmd_sub == SUB_W'(S_MAIN))
        op = OP_CLR;
    end
  end
endmodule

// File: rtl/csr_store.sv
module csr_store
  import csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  csr_op_e          op,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctl_q,
  output logic [N_STROBE-1:0] stb_q
);
  logic [REG_W-1:0]    ctl_d;
  logic                ctl_en;
  logic [N_STROBE-1:0] stb_d;
  logic [REG_W-1:0]    wmask;

  assign wmask = wdata & WR_MASK;

  always_comb begin
    ctl_d  = ctl_q;
    ctl_en = 1'b0;
    stb_d  = '0;
    case (op)
      OP_WRITE: begin
        ctl_d  = wmask;
        ctl_en = 1'b1;
        stb_d  = wdata[N_STROBE-1:0];
      end
      OP_SET: begin
        ctl_d  = ctl_q | wmask;
        ctl_en = 1'b1;
        stb_d  = wdata[N_STROBE-1:0];
      end
      OP_CLR: begin
        ctl_d  = ctl_q & ~wmask;
        ctl_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= RST_VAL;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  for (genvar g = 0; g < N_STROBE; g++) begin : g_stb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q[g] <= 1'b0;
      else        stb_q[g] <= stb_d[g];
    end
  end
endmodule

// File: rtl/csr_readmux.sv
module csr_readmux
  import csr_pkg::*;
#(
  parameter int ATTN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  csr_op_e           op,
  input  logic [REG_W-1:0]  ctl_q,
  input  logic              err_flag,
  input  logic              noresp_flag,
  input  logic              resp_flag,
  input  logic              inhibit_state,
  input  logic              offline_actual,
  input  logic              switch_offline,
  input  logic              attn_present,
  input  logic [ATTN_W-1:0] attn_pattern,
  output logic [REG_W-1:0]  rd_q,
  output logic              rsp_q
);
  logic [REG_W-1:0] stat_word;
  logic [REG_W-1:0] rd_d;
  logic [REG_W-1:0] last_q;
  logic             last_en;
  logic             rsp_d;

  always_comb begin
    stat_word           = '0;
    stat_word[B_INH]    = ctl_q[B_INH];
    stat_word[B_ERR]    = err_flag;
    stat_word[B_NORSP]  = noresp_flag;
    stat_word[B_RSP]    = resp_flag;
    stat_word[B_INHACT] = inhibit_state;
    stat_word[B_DEMEN]  = ctl_q[B_DEMEN];
    stat_word[B_INTDEM] = ctl_q[B_INTDEM];
    stat_word[B_LOOP]   = ctl_q[B_LOOP];
    stat_word[B_BYP]    = ctl_q[B_BYP];
    stat_word[B_OFFL]   = offline_actual;
    stat_word[B_SWOFF]  = switch_offline;
    stat_word[B_ATTN]   = attn_present;
  end

  always_comb begin
    case (op)
      OP_READ:   rd_d = stat_word;
      OP_ATTN:   rd_d = REG_W'(attn_pattern);
      OP_REREAD: rd_d = last_q;
      default:   rd_d = '0;
    endcase
    last_en = (op == OP_READ) || (op == OP_ATTN);
    rsp_d   = (op != OP_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      rsp_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      rsp_q <= rsp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= '0;
    else if (last_en) last_q <= rd_d;
  end
endmodule

// File: rtl/crate_stat_reg.sv
module crate_stat_reg
  import csr_pkg::*;
#(
  parameter int FUNC_W = 5,
  parameter int SUB_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic [SUB_W-1:0]  cmd_sub,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              err_flag,
  input  logic              noresp_flag,
  input  logic              resp_flag,
  input  logic              inhibit_state,
  input  logic              offline_actual,
  input  logic              switch_offline,
  input  logic              attn_present,
  input  logic [DATA_W-1:0] attn_pattern,
  output logic [DATA_W-1:0] rd_data,
  output logic              rsp_ok,
  output logic              init_strobe,
  output logic              clear_strobe,
  output logic              ctl_inhibit,
  output logic              demand_en,
  output logic              int_demand,
  output logic              loop_collapse,
  output logic              bypass,
  output logic              offline_ctl
);
  csr_op_e             op;
  logic [REG_W-1:0]    ctl_q;
  logic [N_STROBE-1:0] stb_q;
  logic [REG_W-1:0]    rd_q;

  csr_decode #(.FUNC_W(FUNC_W), .SUB_W(SUB_W)) u_dec (
    .cmd_valid(cmd_valid), .cmd_func(cmd_func), .cmd_sub(cmd_sub), .op(op)
  );

  csr_store u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .wdata(REG_W'(cmd_wdata)),
    .ctl_q(ctl_q), .stb_q(stb_q)
  );

  csr_readmux #(.ATTN_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .op(op), .ctl_q(ctl_q),
    .err_flag(err_flag), .noresp_flag(noresp_flag), .resp_flag(resp_flag),
    .inhibit_state(inhibit_state), .offline_actual(offline_actual),
    .switch_offline(switch_offline), .attn_present(attn_present),
    .attn_pattern(attn_pattern), .rd_q(rd_q), .rsp_q(rsp_ok)
  );

  assign rd_data       = DATA_W'(rd_q);
  assign init_strobe   = stb_q[B_INIT];
  assign clear_strobe  = stb_q[B_CLEAR];
  assign ctl_inhibit   = ctl_q[B_INH];
  assign demand_en     = ctl_q[B_DEMEN];
  assign int_demand    = ctl_q[B_INTDEM];
  assign loop_collapse = ctl_q[B_LOOP];
  assign bypass        = ctl_q[B_BYP];
  assign offline_ctl   = ctl_q[B_OFFL];
endmodule

// File: rtl/csr_chk.sv
module csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [4:0]  cmd_func,
  input logic [3:0]  cmd_sub,
  input logic [15:0] cmd_wdata,
  input logic [15:0] rd_data,
  input logic        rsp_ok,
  input logic        init_strobe,
  input logic        clear_strobe,
  input logic        ctl_inhibit,
  input logic        demand_en,
  input logic        int_demand,
  input logic        loop_collapse,
  input logic        bypass,
  input logic        offline_ctl
);
  logic [5:0] ctl_vec;
  logic [5:0] clr_sel;
  assign ctl_vec = {offline_ctl, bypass, loop_collapse, int_demand, demand_en, ctl_inhibit};
  assign clr_sel = {cmd_wdata[12:8], cmd_wdata[2]};

  // R8
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_strobe || clear_strobe) |=> !(init_strobe || clear_strobe) || $past(cmd_valid));

  // R11
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_ok && rd_data == 16'h0);

  // R2
  fixed_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] == 1'b0 && rd_data[1] == 1'b0 && rd_data[7] == 1'b0 && rd_data[14] == 1'b0
    || (!$past(cmd_valid)) == 1'b0);

  // R12
  idle_ctl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(ctl_vec) && !init_strobe && !clear_strobe);

  // R7
  clear_under_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_func == 5'd23 && cmd_sub == 4'd0) |=>
      ((ctl_vec & $past(clr_sel)) == 6'h0) && !init_strobe && !clear_strobe);
endmodule

bind crate_stat_reg csr_chk u_csr_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
  .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata), .rd_data(rd_data), .rsp_ok(rsp_ok),
  .init_strobe(init_strobe), .clear_strobe(clear_strobe),
  .ctl_inhibit(ctl_inhibit), .demand_en(demand_en), .int_demand(int_demand),
  .loop_collapse(loop_collapse), .bypass(bypass), .offline_ctl(offline_ctl)
);

// File: tb/test_crate_stat_reg.sv
module test_crate_stat_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [4:0]  cmd_func;
  logic [3:0]  cmd_sub;
  logic [15:0] cmd_wdata;
  logic        err_flag, noresp_flag, resp_flag, inhibit_state;
  logic        offline_actual, switch_offline, attn_present;
  logic [15:0] attn_pattern;
  logic [15:0] rd_data;
  logic        rsp_ok, init_strobe, clear_strobe;
  logic        ctl_inhibit, demand_en, int_demand, loop_collapse, bypass, offline_ctl;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_ctl;
  logic [15:0] m_last;
  bit          done = 1'b0;

  localparam logic [15:0] WMASK = 16'h1F04;

  always #5 clk = ~clk;

  crate_stat_reg i_crate_stat_reg (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata), .err_flag(err_flag),
    .noresp_flag(noresp_flag), .resp_flag(resp_flag), .inhibit_state(inhibit_state),
    .offline_actual(offline_actual), .switch_offline(switch_offline),
    .attn_present(attn_present), .attn_pattern(attn_pattern), .rd_data(rd_data),
    .rsp_ok(rsp_ok), .init_strobe(init_strobe), .clear_strobe(clear_strobe),
    .ctl_inhibit(ctl_inhibit), .demand_en(demand_en), .int_demand(int_demand),
    .loop_collapse(loop_collapse), .bypass(bypass), .offline_ctl(offline_ctl)
  );

  function automatic logic [15:0] ctl_out();
    logic [15:0] v = 16'h0;
    v[2] = ctl_inhibit; v[8] = demand_en; v[9] = int_demand;
    v[10] = loop_collapse; v[11] = bypass; v[12] = offline_ctl;
    return v;
  endfunction

  function automatic logic [15:0] exp_status();
    logic [15:0] v = 16'h0;
    v[2] = m_ctl[2]; v[3] = err_flag; v[4] = noresp_flag; v[5] = resp_flag;
    v[6] = inhibit_state; v[11:8] = m_ctl[11:8]; v[12] = offline_actual;
    v[13] = switch_offline; v[15] = attn_present;
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(string req, logic [4:0] f, logic [3:0] s, logic [15:0] w);
    logic [15:0] e_rd = 16'h0;
    logic        e_rsp = 1'b1;
    logic [1:0]  e_stb = 2'b00;
    logic [15:0] e_ctl;
    cmd_valid = 1'b1; cmd_func = f; cmd_sub = s; cmd_wdata = w;
    {err_flag, noresp_flag, resp_flag, inhibit_state} = 4'($urandom);
    {offline_actual, switch_offline, attn_present}    = 3'($urandom);
    attn_pattern = 16'($urandom);
    e_ctl = m_ctl;
    if (f == 1 && s == 0)       begin e_rd = exp_status(); m_last = e_rd; end
    else if (f == 1 && s == 12) begin e_rd = attn_pattern; m_last = e_rd; end
    else if (f == 0 && s == 1)  e_rd = m_last;
    else if (f == 17 && s == 0) begin e_ctl = w & WMASK; e_stb = w[1:0]; end
    else if (f == 19 && s == 0) begin e_ctl = m_ctl | (w & WMASK); e_stb = w[1:0]; end
    else if (f == 23 && s == 0) e_ctl = m_ctl & ~(w & WMASK);
    else e_rsp = 1'b0;
    m_ctl = e_ctl;
    @(negedge clk);
    check({req, " rd_data"}, 32'(rd_data), 32'(e_rd));
    check({req, " rsp_ok"},  32'(rsp_ok),  32'(e_rsp));
    check({req, " strobes R8"}, 32'({clear_strobe, init_strobe}), 32'(e_stb));
    check({req, " controls"}, 32'(ctl_out()), 32'(m_ctl));
    cmd_valid = 1'b0;
    @(negedge clk);
    check("R8 R11 idle after cmd", 32'({rsp_ok, clear_strobe, init_strobe, rd_data}), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9626));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_func = '0; cmd_sub = '0; cmd_wdata = '0;
    {err_flag, noresp_flag, resp_flag, inhibit_state} = '0;
    {offline_actual, switch_offline, attn_present} = '0;
    attn_pattern = '0;
    m_ctl = 16'h1804; m_last = 16'h0;
    repeat (3) @(negedge clk);
    check("R1 reset controls", 32'(ctl_out()), 32'h1804);
    check("R1 reset outputs", 32'({rsp_ok, clear_strobe, init_strobe, rd_data}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: re-read before any read gives 0; R2 status after reset
    do_cmd("R1 R4 reread at reset", 0, 1, 16'h0);
    do_cmd("R2 R9 read reset", 1, 0, 16'h0);
    // R5 R10 full write of all ones, then zeros
    do_cmd("R5 R10 write ones", 17, 0, 16'hFFFC);
    do_cmd("R2 R9 read after write", 1, 0, 16'h0);
    do_cmd("R5 write zeros", 17, 0, 16'h0000);
    // R6 / R7 selective
    do_cmd("R6 set", 19, 0, 16'h0A04);
    do_cmd("R7 clear", 23, 0, 16'h0804);
    do_cmd("R3 attn", 1, 12, 16'h0);
    do_cmd("R12 unsupported", 17, 1, 16'hFFFF);
    do_cmd("R4 reread after other cmds", 0, 1, 16'h0);
    // R8 strobes
    do_cmd("R8 init strobe", 17, 0, 16'h0001);
    do_cmd("R8 clear strobe", 19, 0, 16'h0002);
    do_cmd("R8 clr no strobe", 23, 0, 16'h0003);
    do_cmd("R12 unsupported 2", 2, 0, 16'hFFFF);
    do_cmd("R10 read-only bits", 19, 0, 16'hE0F8);
    do_cmd("R2 R10 read", 1, 0, 16'h0);
    for (int i = 0; i < 400; i++) begin
      logic [4:0] f;
      logic [3:0] s;
      case ($urandom % 7)
        0: begin f = 1;  s = 0;  end
        1: begin f = 1;  s = 12; end
        2: begin f = 0;  s = 1;  end
        3: begin f = 17; s = 0;  end
        4: begin f = 19; s = 0;  end
        5: begin f = 23; s = 0;  end
        default: begin f = 5'($urandom); s = 4'($urandom); end
      endcase
      do_cmd("R2-mix random", f, s, 16'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule